// File: doc/BRIEF.md
# PLL Lock-Change Control Register

This block is an 8-bit memory-mapped control and status register for a clock-generator PLL. It holds four bits: an interrupt enable, a sticky lock-change flag, the PLL power switch and the base-clock selector. It watches an asynchronous lock indication from the PLL. It also watches a mode input that tells it whether automatic bandwidth control is active. Every transition of the lock indication sets the flag. An interrupt request is raised while the flag and the enable are both set and automatic mode is on. Reading the register clears the flag.

The bus side is a simple strobed port. A select line, a read strobe and a write strobe, together with an 8-bit address, qualify each access. Write data is taken at the clock edge. Read data is returned combinationally in the same cycle as the read strobe.

Two small state machines do the work:
- **Lock tracker.** A synchronizer feeds a tracker with states `LK_LOW` and `LK_HIGH`. Its transitions `LK_LOW→LK_HIGH` (rise) and `LK_HIGH→LK_LOW` (fall) each emit a one-cycle change pulse.
- **Flag machine.** This machine has states `FL_CLEAR` and `FL_PENDING`.
  - `FL_CLEAR→FL_PENDING` happens on a change pulse.
  - `FL_PENDING→FL_CLEAR` happens on a register read when no change pulse arrives in the same cycle.
  - `FL_PENDING→FL_PENDING` covers a change pulse, or idle cycles.

Top module: `pll_lockctl_reg`

## Requirements
- R1: The register answers only when `sel` is high and `addr` equals 0x1C. A read at any other address returns 0x00, and a write at any other address changes no register bit.
- R2: After reset the register reads 0x2F. In that value bit 7 (enable) is 0, bit 6 (flag) is 0, bit 5 (PLL on) is 1, bit 4 (base select) is 0, and bits 3..0 are 1. Also after reset `pll_on` is 1, `base_sel` is 0 and `irq` is 0.
- R3: A rising or a falling change of `lock_in` sets the flag, which is bit 6. The flag is visible after the third rising clock edge that follows the change.
- R4: A register read returns the flag's current value in the same cycle. From the next edge onward the flag reads 0, unless a new lock change arrived.
- R5: When a lock change pulse and a register read fall in the same cycle, the flag stays set after that cycle.
- R6: `irq` is high exactly while the enable (bit 7), the flag and `auto_mode` are all 1.
- R7: While `auto_mode` is 0:
  - writes to bit 7 are ignored;
  - bits 7 and 6 read as 0;
  - `irq` is 0.
  The stored enable reappears when `auto_mode` returns to 1.
- R8: Bits 5 and 4 are read/write and drive `pll_on` and `base_sel` from the edge that writes them. Written values of bit 6 and of bits 3..0 have no effect, and bits 3..0 always read 1.
- R9: `rdata` is 0x00 in any cycle without a read strobe to the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Block select |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle of the read strobe |
| lock_in | input | 1 | Asynchronous PLL lock indication |
| auto_mode | input | 1 | Automatic bandwidth mode active |
| pll_on | output | 1 | PLL power switch |
| base_sel | output | 1 | Base clock select |
| irq | output | 1 | Lock-change interrupt request |

## Verification
Read data and the `auto_mode` gating of `irq` are combinational. The bench therefore drives them just after a falling edge and samples one time unit later, in the same cycle. Register writes take effect at the next rising edge, so they are checked from the following falling edge. A `lock_in` change passes two synchronizer stages and then the tracker's change pulse, which puts the flag and `irq` on the third rising edge. The bench checks that `irq` is still low after the second edge and high after the third. The same-cycle collision test times its read strobe to the cycle between the second and third edges, which is when the change pulse is active.

// File: rtl/pll_lockctl_pkg.sv
package pll_lockctl_pkg;
    localparam int REG_W    = 8;
    localparam int BIT_IE   = 7;
    localparam int BIT_FLAG = 6;
    localparam int BIT_ON   = 5;
    localparam int BIT_BASE = 4;
    localparam int RSV_W    = 4;

    typedef enum logic {LK_LOW = 1'b0, LK_HIGH = 1'b1} lk_state_t;
    typedef enum logic {FL_CLEAR = 1'b0, FL_PENDING = 1'b1} fl_state_t;
endpackage

// File: rtl/pll_lock_tracker.sv
module pll_lock_tracker #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_async,
    output logic lock_chg
);
    import pll_lockctl_pkg::*;

    logic [SYNC_STAGES-1:0] sync_q;
    lk_state_t              state_q, state_d;
    logic                   lock_s;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= lock_async;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], lock_async};
            end
        end
    endgenerate

    assign lock_s = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        lock_chg = 1'b0;
        unique case (state_q)
            LK_LOW: if (lock_s) begin
                state_d  = LK_HIGH;
                lock_chg = 1'b1;
            end
            LK_HIGH: if (!lock_s) begin
                state_d  = LK_LOW;
                lock_chg = 1'b1;
            end
        endcase
    end

    // R3: the tracker follows the synchronized level one edge later
    assert_track_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lock_chg |=> (state_q == lk_state_t'($past(lock_s))));
endmodule

// File: rtl/pll_flag_fsm.sv
module pll_flag_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_chg,
    input  logic rd_hit,
    output logic flag
);
    import pll_lockctl_pkg::*;

    fl_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FL_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_CLEAR:   if (lock_chg) state_d = FL_PENDING;
            FL_PENDING: if (rd_hit && !lock_chg) state_d = FL_CLEAR;
        endcase
    end

    assign flag = (state_q == FL_PENDING);

    assert_flag_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lock_chg |=> flag);
    assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && !lock_chg) |=> !flag);
    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && lock_chg) |=> flag);
endmodule

// File: rtl/pll_ctl_bits.sv
module pll_ctl_bits (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic auto_mode,
    input  logic ie_wd,
    input  logic on_wd,
    input  logic base_wd,
    output logic ie,
    output logic pll_on,
    output logic base_sel
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie       <= 1'b0;
            pll_on   <= 1'b1;
            base_sel <= 1'b0;
        end else if (wr_hit) begin
            pll_on   <= on_wd;
            base_sel <= base_wd;
            if (auto_mode) ie <= ie_wd;
        end
    end

    assert_ie_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !auto_mode) |=> $stable(ie));
    assert_on_written_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (pll_on == $past(on_wd)) && (base_sel == $past(base_wd)));
    assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable({ie, pll_on, base_sel}));
endmodule

// File: rtl/pll_lockctl_reg.sv
module pll_lockctl_reg
    import pll_lockctl_pkg::*;
#(
    parameter int         ADDR_W      = 8,
    parameter logic [7:0] REG_ADDR    = 8'h1C,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              lock_in,
    input  logic              auto_mode,
    output logic              pll_on,
    output logic              base_sel,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

    logic hit, rd_hit, wr_hit, lock_chg, flag, ie;
    logic [REG_W-1:0] word;

    assign hit    = sel && (addr == HIT_ADDR);
    assign rd_hit = hit && rd_en;
    assign wr_hit = hit && wr_en;

    pll_lock_tracker #(.SYNC_STAGES(SYNC_STAGES)) u_track (
        .clk(clk), .rst_n(rst_n), .lock_async(lock_in), .lock_chg(lock_chg)
    );

    pll_flag_fsm u_flag (
        .clk(clk), .rst_n(rst_n), .lock_chg(lock_chg), .rd_hit(rd_hit), .flag(flag)
    );

    pll_ctl_bits u_bits (
        .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .auto_mode(auto_mode),
        .ie_wd(wdata[BIT_IE]), .on_wd(wdata[BIT_ON]), .base_wd(wdata[BIT_BASE]),
        .ie(ie), .pll_on(pll_on), .base_sel(base_sel)
    );

    always_comb begin
        word           = '0;
        word[BIT_IE]   = ie && auto_mode;
        word[BIT_FLAG] = flag && auto_mode;
        word[BIT_ON]   = pll_on;
        word[BIT_BASE] = base_sel;
        word[RSV_W-1:0] = '1;
    end

    assign rdata = rd_hit ? word : '0;
    assign irq   = auto_mode && ie && flag;

    assert_irq_manual_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_mode |-> !irq);
    assert_idle_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |-> (rdata == '0));
    assert_rsv_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |-> (rdata[RSV_W-1:0] == '1));
    assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> rdata[BIT_FLAG] || !rd_hit);
endmodule

// File: tb/pll_lockctl_reg_bench.sv
`timescale 1ns/1ps
module pll_lockctl_reg_bench;
    logic clk = 1'b0, rst_n = 1'b0;
    logic sel = 0, rd_en = 0, wr_en = 0, lock_in = 0, auto_mode = 1;
    logic [7:0] addr = 8'h00, wdata = 8'h00, rdata;
    logic pll_on, base_sel, irq;
    int total = 0, bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pll_lockctl_reg u_pll_lockctl_reg (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .lock_in(lock_in),
        .auto_mode(auto_mode), .pll_on(pll_on), .base_sel(base_sel), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        sel = 1; rd_en = 1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        sel = 0; rd_en = 0;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sel = 1; wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        sel = 0; wr_en = 0;
    endtask

    task automatic toggle_lock_settle(input logic v);
        @(negedge clk) lock_in = v;
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        #1;
        check("R2 pll_on", {7'd0, pll_on}, 8'h01);
        check("R2 base_sel", {7'd0, base_sel}, 8'h00);
        check("R2 irq", {7'd0, irq}, 8'h00);
        do_read(8'h1C, d);
        check("R2 read", d, 8'h2F);
    endtask

    task automatic t_decode;
        logic [7:0] d;
        do_read(8'h1D, d);
        check("R1 other addr read", d, 8'h00);
        do_write(8'h1D, 8'h10);
        #1 check("R1 other addr write base_sel", {7'd0, base_sel}, 8'h00);
        do_read(8'h1C, d);
        check("R1 reg unchanged", d, 8'h2F);
        #1 check("R9 idle rdata", rdata, 8'h00);
        @(negedge clk); sel = 1; addr = 8'h1C; #1;
        check("R9 select without strobe", rdata, 8'h00);
        sel = 0;
    endtask

    task automatic t_rw_bits;
        logic [7:0] d;
        do_write(8'h1C, 8'h50);
        #1 check("R8 pll_on written 0", {7'd0, pll_on}, 8'h00);
        check("R8 base_sel written 1", {7'd0, base_sel}, 8'h01);
        do_read(8'h1C, d);
        check("R8 read after write", d, 8'h1F);
        do_write(8'h1C, 8'h20);
        do_read(8'h1C, d);
        check("R8 restore", d, 8'h2F);
    endtask

    task automatic t_flag_edges;
        logic [7:0] d;
        do_write(8'h1C, 8'hA0);
        @(negedge clk) lock_in = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R3 not before third edge", {7'd0, irq}, 8'h00);
        @(posedge clk); @(negedge clk);
        check("R6 irq on flag", {7'd0, irq}, 8'h01);
        do_read(8'h1C, d);
        check("R3 rise sets flag", d, 8'hEF);
        #1 check("R6 irq cleared", {7'd0, irq}, 8'h00);
        do_read(8'h1C, d);
        check("R4 read cleared flag", d, 8'hAF);
        toggle_lock_settle(0);
        do_read(8'h1C, d);
        check("R3 fall sets flag", d, 8'hEF);
    endtask

    task automatic t_set_wins;
        logic [7:0] d;
        toggle_lock_settle(1);
        @(negedge clk) lock_in = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        sel = 1; rd_en = 1; addr = 8'h1C;
        #1 d = rdata;
        @(negedge clk); sel = 0; rd_en = 0;
        check("R5 collision read", d, 8'hEF);
        do_read(8'h1C, d);
        check("R5 flag kept", d, 8'hEF);
        do_read(8'h1C, d);
        check("R4 then cleared", d, 8'hAF);
    endtask

    task automatic t_irq_no_enable;
        logic [7:0] d;
        do_write(8'h1C, 8'h20);
        toggle_lock_settle(1);
        check("R6 no irq without enable", {7'd0, irq}, 8'h00);
        do_read(8'h1C, d);
        check("R6 flag still set", d, 8'h6F);
    endtask

    task automatic t_auto_off;
        logic [7:0] d;
        do_write(8'h1C, 8'hA0);
        toggle_lock_settle(0);
        check("R6 irq with enable", {7'd0, irq}, 8'h01);
        @(negedge clk) auto_mode = 0;
        #1 check("R7 irq gated", {7'd0, irq}, 8'h00);
        do_read(8'h1C, d);
        check("R7 enable and flag read 0", d, 8'h2F);
        do_write(8'h1C, 8'h20);
        @(negedge clk) auto_mode = 1;
        do_read(8'h1C, d);
        check("R7 enable write ignored", d, 8'hAF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_decode();
        t_rw_bits();
        t_flag_edges();
        t_set_wins();
        t_irq_no_enable();
        t_auto_off();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule